// File: doc/BRIEF.md
# Power-on debug access gate

This block runs once per power-on, while the processor is still held in reset. It fetches two words from nonvolatile configuration storage over a simple fixed-latency read port: a protection word and a debug-control word. From them it decides whether the external debug port may reach the system bus, and whether intrusive CPU debug (halt, step, debugger breakpoints) is allowed. It also sets separate enables for the breakpoint/patch unit and for non-intrusive trace. Only after both words are captured does it let the CPU out of reset.

Debug access is closed by default. It opens only when all 32 bits of the protection word read as erased ones. The decision is made and held in hardware, with no firmware involved. A new power-on reset is the only way to change it.

Top module: `dbg_gate_top`

## Requirements
- R1: While rst_ni is low, cpu_rst_rel_o, dbg_bus_en_o, cpu_dbg_en_o, patch_en_o, trace_en_o and cfg_req_o are all 0.
- R2: After reset the block issues exactly two one-cycle read requests. The first is at PROT_ADDR (default 0x00) and the second is at CTL_ADDR (default 0x04). Read data is taken RD_LAT cycles after the cycle in which the request was high.
- R3: cpu_rst_rel_o rises at the (4 + 2*RD_LAT)-th rising clock edge after rst_ni goes high, which is the 8th edge with default RD_LAT = 2. It then stays high until the next reset.
- R4: dbg_bus_en_o is 1 only when the protection word equals 0xFFFF_FFFF. Any other value, including a single cleared bit, keeps it 0.
- R5: cpu_dbg_en_o always equals dbg_bus_en_o. Intrusive CPU debug follows the protection decision.
- R6: patch_en_o is 1 only when the debug-control field at bits [7:0] is 8'hFF and debug access is enabled. Otherwise it is 0.
- R7: trace_en_o is 1 only when the debug-control field at bits [15:8] is 8'hFF and debug access is enabled. Bits [31:16] of the control word have no effect.
- R8: All debug enables stay 0 until the sequence completes. They take their final values on the same edge that raises cpu_rst_rel_o.
- R9: Once cpu_rst_rel_o is high, no further reads are issued. Changes on cfg_rdata_i or in the storage contents do not alter any output until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cfg_req_o | output | 1 | One-cycle read request to configuration storage |
| cfg_addr_o | output | AW | Read address, valid while cfg_req_o is high |
| cfg_rdata_i | input | 32 | Read data, valid RD_LAT cycles after the request cycle |
| cpu_rst_rel_o | output | 1 | CPU reset release (1 = run) |
| dbg_bus_en_o | output | 1 | Debug port may access the system bus |
| cpu_dbg_en_o | output | 1 | Intrusive CPU debug allowed |
| patch_en_o | output | 1 | Breakpoint/patch unit enabled |
| trace_en_o | output | 1 | Non-intrusive trace enabled |

## Verification
Two things happen on the same clock edge: the decoded enables are loaded, and cpu_rst_rel_o is asserted. A wrong edge for either one would briefly expose a mismatched state. The bench samples all enables one edge before release and on the release edge itself, and requires them to be all-zero and then final together. It also starts driving garbage read data and flipped storage contents in the cycle after release, so that any late capture shows up as a changed output.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_PROT,
    S_WT_PROT,
    S_RD_CTL,
    S_WT_CTL,
    S_REL,
    S_DONE
  } seq_st_e;

  typedef struct packed {
    logic bus;
    logic cpu;
    logic patch;
    logic trace;
  } dbg_en_t;
endpackage

// File: rtl/dbg_gate_seq.sv
module dbg_gate_seq
  import dbg_gate_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned RD_LAT    = 2,
  parameter logic [AW-1:0] PROT_ADDR = 'h00,
  parameter logic [AW-1:0] CTL_ADDR  = 'h04
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          cfg_req_o,
  output logic [AW-1:0] cfg_addr_o,
  output logic          prot_stb_o,
  output logic          ctl_stb_o,
  output logic          rel_stb_o
);
  localparam int unsigned CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(RD_LAT - 1);

  seq_st_e st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic in_wait, cnt_last;

  assign in_wait  = (st_q == S_WT_PROT) || (st_q == S_WT_CTL);
  assign cnt_last = (cnt_q == LAST);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    st_d = S_RD_PROT;
      S_RD_PROT: st_d = S_WT_PROT;
      S_WT_PROT: if (cnt_last) st_d = S_RD_CTL;
      S_RD_CTL:  st_d = S_WT_CTL;
      S_WT_CTL:  if (cnt_last) st_d = S_REL;
      S_REL:     st_d = S_DONE;
      S_DONE:    st_d = S_DONE;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (in_wait && !cnt_last) cnt_q <= cnt_q + 1'b1;
      else                      cnt_q <= '0;
    end
  end

  assign cfg_req_o  = (st_q == S_RD_PROT) || (st_q == S_RD_CTL);
  assign cfg_addr_o = (st_q == S_RD_CTL) ? CTL_ADDR :
                      (st_q == S_RD_PROT) ? PROT_ADDR : '0;
  assign prot_stb_o = (st_q == S_WT_PROT) && cnt_last;
  assign ctl_stb_o  = (st_q == S_WT_CTL) && cnt_last;
  assign rel_stb_o  = (st_q == S_REL);

  // requests are single-cycle pulses
  p_req_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |=> !cfg_req_o);

  // release strobe follows the control capture directly
  p_rel_after_ctl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_stb_o |-> $past(ctl_stb_o));

  p_stb_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_stb_o |=> !ctl_stb_o);
endmodule

// File: rtl/dbg_gate_word_reg.sv
module dbg_gate_word_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // reset value 0 = protected / disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (stb_i) q_o <= d_i;
  end
endmodule

// File: rtl/dbg_gate_decode.sv
module dbg_gate_decode
  import dbg_gate_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter int unsigned FLD_W     = 8,
  parameter int unsigned PATCH_LSB = 0,
  parameter int unsigned TRACE_LSB = 8
) (
  input  logic [W-1:0] prot_i,
  input  logic [W-1:0] ctl_i,
  output dbg_en_t      en_o
);
  localparam int unsigned NFLD = 2;
  localparam int unsigned FLD_LSB [NFLD] = '{PATCH_LSB, TRACE_LSB};

  logic open_dbg;
  logic [NFLD-1:0] fld_on;
  logic unused_ctl;

  assign open_dbg = &prot_i;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    assign fld_on[g] = &ctl_i[FLD_LSB[g] +: FLD_W];
  end

  assign unused_ctl = ^ctl_i;

  assign en_o.bus   = open_dbg;
  assign en_o.cpu   = open_dbg;
  assign en_o.patch = open_dbg & fld_on[0];
  assign en_o.trace = open_dbg & fld_on[1];
endmodule

// File: rtl/dbg_gate_top.sv
module dbg_gate_top
  import dbg_gate_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned RD_LAT    = 2,
  parameter logic [AW-1:0] PROT_ADDR = 'h00,
  parameter logic [AW-1:0] CTL_ADDR  = 'h04,
  parameter int unsigned FLD_W     = 8,
  parameter int unsigned PATCH_LSB = 0,
  parameter int unsigned TRACE_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cfg_req_o,
  output logic [AW-1:0]     cfg_addr_o,
  input  logic [WORD_W-1:0] cfg_rdata_i,
  output logic              cpu_rst_rel_o,
  output logic              dbg_bus_en_o,
  output logic              cpu_dbg_en_o,
  output logic              patch_en_o,
  output logic              trace_en_o
);
  logic prot_stb, ctl_stb, rel_stb;
  logic [WORD_W-1:0] prot_q, ctl_q;
  dbg_en_t en_d, en_q;
  logic rel_q;

  dbg_gate_seq #(
    .AW(AW), .RD_LAT(RD_LAT), .PROT_ADDR(PROT_ADDR), .CTL_ADDR(CTL_ADDR)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_req_o(cfg_req_o), .cfg_addr_o(cfg_addr_o),
    .prot_stb_o(prot_stb), .ctl_stb_o(ctl_stb), .rel_stb_o(rel_stb)
  );

  dbg_gate_word_reg #(.W(WORD_W)) u_prot (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(prot_stb), .d_i(cfg_rdata_i), .q_o(prot_q)
  );

  dbg_gate_word_reg #(.W(WORD_W)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(ctl_stb), .d_i(cfg_rdata_i), .q_o(ctl_q)
  );

  dbg_gate_decode #(
    .W(WORD_W), .FLD_W(FLD_W), .PATCH_LSB(PATCH_LSB), .TRACE_LSB(TRACE_LSB)
  ) u_dec (
    .prot_i(prot_q), .ctl_i(ctl_q), .en_o(en_d)
  );

  // enables and release load on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      rel_q <= 1'b0;
    end else if (rel_stb) begin
      en_q  <= en_d;
      rel_q <= 1'b1;
    end
  end

  assign cpu_rst_rel_o = rel_q;
  assign dbg_bus_en_o  = en_q.bus;
  assign cpu_dbg_en_o  = en_q.cpu;
  assign patch_en_o    = en_q.patch;
  assign trace_en_o    = en_q.trace;

  p_release_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_rel_o |=> cpu_rst_rel_o);

  p_en_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_rel_o |=> $stable({dbg_bus_en_o, cpu_dbg_en_o, patch_en_o, trace_en_o}));

  p_no_req_after_rel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_rel_o |-> !cfg_req_o);

  p_en_before_rel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_bus_en_o || patch_en_o || trace_en_o) |-> cpu_rst_rel_o);

  p_cpu_follows_bus_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_dbg_en_o == dbg_bus_en_o);

  p_patch_needs_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    patch_en_o |-> dbg_bus_en_o);

  p_trace_needs_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_en_o |-> dbg_bus_en_o);
endmodule

// File: tb/dbg_gate_top_bench.sv
module dbg_gate_top_bench;
  localparam int unsigned RD_LAT = 2;
  localparam int unsigned REL_EDGE = 4 + 2 * RD_LAT;
  localparam logic [7:0] A_PROT = 8'h00;
  localparam logic [7:0] A_CTL  = 8'h04;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req;
  logic [7:0] addr;
  logic [31:0] rdata;
  logic rel, bus_en, cpu_en, patch_en, trace_en;

  logic [31:0] mem_prot = '0, mem_ctl = '0;
  logic glitch = 1'b0;
  logic [31:0] stg [RD_LAT];

  int errors = 0, checks = 0;
  int n_req = 0;
  logic [7:0] req_addr [4];
  logic [3:0] exp_q [$];
  logic rel_prev = 1'b0;
  bit finished = 0;

  always #5 clk = ~clk;

  dbg_gate_top #(.RD_LAT(RD_LAT)) u_dbg_gate_top (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_o(req), .cfg_addr_o(addr),
    .cfg_rdata_i(rdata), .cpu_rst_rel_o(rel), .dbg_bus_en_o(bus_en),
    .cpu_dbg_en_o(cpu_en), .patch_en_o(patch_en), .trace_en_o(trace_en)
  );

  // storage stub with fixed read latency
  always @(posedge clk) begin
    if (req) stg[0] <= (addr == A_PROT) ? mem_prot : (addr == A_CTL) ? mem_ctl : 32'hDEAD_BEEF;
    else     stg[0] <= 32'h0;
    for (int k = 1; k < RD_LAT; k++) stg[k] <= stg[k-1];
  end
  assign rdata = glitch ? 32'hFFFF_FFFF : stg[RD_LAT-1];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // request monitor
  always @(negedge clk) begin
    if (rst_n && req) begin
      if (n_req < 4) req_addr[n_req] = addr;
      n_req++;
    end
  end

  // scoreboard monitor: compare on release rising
  always @(negedge clk) begin
    if (!rst_n) rel_prev = 1'b0;
    else begin
      if (rel && !rel_prev) begin
        if (exp_q.size() == 0) chk(0, "R4/R5/R6/R7 scoreboard empty", 32'(1), 32'(0));
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk({bus_en, cpu_en, patch_en, trace_en} == e, "R4/R5/R6/R7 enables",
              32'({bus_en, cpu_en, patch_en, trace_en}), 32'(e));
        end
      end
      rel_prev = rel;
    end
  end

  function automatic logic [3:0] expect_en(input logic [31:0] p, input logic [31:0] c);
    logic b;
    b = (p == 32'hFFFF_FFFF);
    return {b, b, b && (c[7:0] == 8'hFF), b && (c[15:8] == 8'hFF)};
  endfunction

  task automatic run_case(input logic [31:0] p, input logic [31:0] c);
    logic [3:0] e;
    e = expect_en(p, c);
    @(negedge clk);
    rst_n = 1'b0;
    glitch = 1'b0;
    mem_prot = p;
    mem_ctl = c;
    exp_q.push_back(e);
    repeat (2) @(negedge clk);
    n_req = 0;
    chk({rel, bus_en, cpu_en, patch_en, trace_en, req} == 6'b0, "R1 reset state",
        32'({rel, bus_en, cpu_en, patch_en, trace_en, req}), 32'(0));
    rst_n = 1'b1;
    for (int k = 1; k <= int'(REL_EDGE); k++) begin
      @(negedge clk);
      if (k == int'(REL_EDGE) - 1)
        chk({rel, bus_en, cpu_en, patch_en, trace_en} == 5'b0, "R8 R3 held before release",
            32'({rel, bus_en, cpu_en, patch_en, trace_en}), 32'(0));
      if (k == int'(REL_EDGE))
        chk(rel == 1'b1, "R3 release edge", 32'(rel), 32'(1));
    end
    chk(n_req == 2 && req_addr[0] == A_PROT && req_addr[1] == A_CTL, "R2 read order",
        {8'(n_req), 8'h0, req_addr[0], req_addr[1]}, {8'd2, 8'h0, A_PROT, A_CTL});
    glitch = 1'b1;
    mem_prot = ~p;
    mem_ctl = ~c;
    repeat (6) @(negedge clk);
    chk({rel, bus_en, cpu_en, patch_en, trace_en} == {1'b1, e} && n_req == 2, "R9 hold after release",
        {27'(n_req), rel, bus_en, cpu_en, patch_en, trace_en}, {27'd2, 1'b1, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF); // R4 open, all on
    run_case(32'hFFFF_FFFE, 32'hFFFF_FFFF); // R4 one bit cleared
    run_case(32'h7FFF_FFFF, 32'hFFFF_FFFF); // R4 top bit cleared
    run_case(32'h0000_0000, 32'hFFFF_FFFF); // R4 programmed
    run_case(32'hFFFF_FFFF, 32'hFFFF_FF00); // R6 patch off
    run_case(32'hFFFF_FFFF, 32'hFFFF_00FF); // R7 trace off
    run_case(32'hFFFF_FFFF, 32'h0000_FFFF); // R7 upper bits ignored
    run_case(32'hFFFF_FFFF, 32'hFFFF_FFFE); // R6 single field bit
    run_case(32'h1234_5678, 32'hFFFF_FFFF); // R5 R6 R7 forced off
    // R1 asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #1 chk({rel, bus_en, cpu_en, patch_en, trace_en} == 5'b0, "R1 async reset",
           32'({rel, bus_en, cpu_en, patch_en, trace_en}), 32'(0));
    chk(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'(0));
    finished = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 32'(0), 32'(1));
      report();
    end
  end
endmodule